// File: doc/BRIEF.md
# Diagonal-Replicating Parse Table Builder

This block builds the dotted-rule parse table of a chart parser for one special case. The input is a string of `n` copies of a single dummy terminal. Because every input position is the same symbol, every cell that lies on one diagonal of the table (same `col - row`) holds the same set of dotted rules. The block uses this: it computes only the cells of row 0, one column at a time, and writes each finished cell onto every cell of its diagonal that lies inside the `(n+1) x (n+1)` upper triangle.

The grammar is a small rule ROM presented on input ports:
- one left-hand symbol per rule,
- one right-hand length per rule,
- up to `MAXLEN` right-hand symbols per rule.

A start pulse together with a length begins a build. The block gives one strobe per finished column. After the last column it drives an accept flag. A read port returns any table cell, so the semantic stages that come after this block can walk the table.

Top module: `pt_diag_builder`

## Requirements
- R1: After reset, `accept` and `col_done` are low and every table read returns zero.
- R2: A `start` pulse is taken only while the block is idle and only with 1 <= `n_in` <= `NMAX`. A pulse with `n_in` of 0, with `n_in` above `NMAX`, or during a build is ignored. An ignored pulse gives no strobe and changes neither the flag nor the table.
- R3: A cell is an `NRULE*(MAXLEN+1)`-bit vector. Bit `r*(MAXLEN+1)+d` means rule `r` with its first `d` right-hand symbols matched. Symbol code 0 is the dummy terminal. Rule 0 is the start rule. Every rule length is at least 1, and the grammar is held stable during a build.
- R4: Each diagonal cell `(i,i)` with `i <= n` holds the prediction closure of the start item (rule 0, dot 0): the dot-0 items of every rule that can be reached through leading nonterminals.
- R5: Cell `(0,j)` for `j >= 1` is built from three kinds of terms:
  - the dot-advanced items of `(0,j-1)` whose next symbol is the terminal;
  - for every `k` with `0 < k < j`, the items of `(0,k)` advanced over a symbol that is the left side of a completed item in `(k,j)`;
  - the items obtained by repeatedly advancing the diagonal cell's items in the same way over completions inside the cell being built.
- R6: Every cell `(i,i+j)` with `i+j <= n` holds exactly the contents of `(0,j)`.
- R7: An accepted start clears the whole table. After a build, cells below the diagonal and cells with a column above `n` read zero.
- R8: A build gives exactly `n+1` single-cycle `col_done` pulses, with `col_idx` counting 0, 1, ..., n. Each pulse comes after that column's last table write, and no two pulses fall on adjacent cycles.
- R9: `accept` is cleared by an accepted start. It is set at the last strobe exactly when cell `(0,n)` contains rule 0 with its dot at the end, and it keeps that value until the next accepted start.
- R10: A read returns the addressed cell one clock after the address is presented. A row or column above `NMAX` reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Build request pulse |
| n_in | input | CW | Input length for the build |
| rule_lhs | input | NRULE*SW | Left-hand symbol of each rule |
| rule_len | input | NRULE*LW | Right-hand length of each rule |
| rule_rhs | input | NRULE*MAXLEN*SW | Right-hand symbols, rule-major |
| rd_row | input | CW | Read row |
| rd_col | input | CW | Read column |
| rd_data | output | NB | Cell contents, one cycle after the address |
| col_done | output | 1 | Column finished and replicated |
| col_idx | output | CW | Index of the finished column |
| accept | output | 1 | Start rule completed over the whole input |

## Verification
A wrong row-0 cell cannot stay hidden. It is written along its whole diagonal at once, so a table walk after the build shows the same wrong vector in up to `n+1` places. It also feeds the completer terms of every later column, so a wrong closure or completer step changes the cells of all following columns and usually the accept flag. A fault in the replication counter appears at the ports as a missing, extra or misordered column strobe, or as a non-zero cell outside the triangle, before the build ends.

// File: rtl/pt_pkg.sv
package pt_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SEED,
    ST_CLOSE0,
    ST_SCAN,
    ST_COMP,
    ST_CLOSE,
    ST_REPL
  } pt_state_e;

  // Position of the (rule, dot) item inside a cell vector.
  function automatic int unsigned item_pos(input int unsigned rule,
                                           input int unsigned dot,
                                           input int unsigned per_rule);
    return rule * per_rule + dot;
  endfunction

endpackage

// File: rtl/pt_rule_decode.sv
module pt_rule_decode #(
  parameter int NRULE  = 8,
  parameter int MAXLEN = 3,
  parameter int NSYM   = 8,
  localparam int SW  = $clog2(NSYM),
  localparam int LW  = $clog2(MAXLEN + 1),
  localparam int BPR = MAXLEN + 1,
  localparam int NB  = NRULE * BPR
) (
  input  logic [NRULE*SW-1:0]        rule_lhs,
  input  logic [NRULE*LW-1:0]        rule_len,
  input  logic [NRULE*MAXLEN*SW-1:0] rule_rhs,
  output logic [NB-1:0]              item_end,
  output logic [NB-1:0]              item_open,
  output logic [NB*SW-1:0]           item_next,
  output logic [NB*SW-1:0]           item_lhs
);

  for (genvar r = 0; r < NRULE; r++) begin : g_rule
    logic [LW-1:0] len_r;
    assign len_r = rule_len[r*LW +: LW];
    for (genvar d = 0; d <= MAXLEN; d++) begin : g_dot
      localparam int B = r * BPR + d;
      assign item_end[B]          = (len_r == LW'(d));
      assign item_open[B]         = (LW'(d) < len_r);
      assign item_lhs[B*SW +: SW] = rule_lhs[r*SW +: SW];
      if (d < MAXLEN) begin : g_sym
        assign item_next[B*SW +: SW] = rule_rhs[(r*MAXLEN + d)*SW +: SW];
      end else begin : g_last
        assign item_next[B*SW +: SW] = '0;
      end
    end
  end

endmodule

// File: rtl/pt_combine.sv
module pt_combine #(
  parameter int NRULE  = 8,
  parameter int MAXLEN = 3,
  parameter int NSYM   = 8,
  localparam int SW  = $clog2(NSYM),
  localparam int BPR = MAXLEN + 1,
  localparam int NB  = NRULE * BPR
) (
  input  logic [NB-1:0]    left_cell,
  input  logic [NB-1:0]    right_cell,
  input  logic [NB-1:0]    item_end,
  input  logic [NB-1:0]    item_open,
  input  logic [NB*SW-1:0] item_next,
  input  logic [NB*SW-1:0] item_lhs,
  output logic [NB-1:0]    scan_adv,
  output logic [NB-1:0]    comp_adv,
  output logic [NB-1:0]    predicted
);

  logic [NSYM-1:0] done_syms;
  logic [NSYM-1:0] want_syms;

  always_comb begin
    done_syms = '0;
    want_syms = '0;
    for (int b = 0; b < NB; b++) begin
      if (right_cell[b] && item_end[b])
        done_syms[item_lhs[b*SW +: SW]] = 1'b1;
      if (left_cell[b] && item_open[b] && (item_next[b*SW +: SW] != '0))
        want_syms[item_next[b*SW +: SW]] = 1'b1;
    end
  end

  always_comb begin
    scan_adv  = '0;
    comp_adv  = '0;
    predicted = '0;
    for (int b = 0; b < NB - 1; b++) begin
      if (left_cell[b] && item_open[b]) begin
        if (item_next[b*SW +: SW] == '0)
          scan_adv[b+1] = 1'b1;
        else if (done_syms[item_next[b*SW +: SW]])
          comp_adv[b+1] = 1'b1;
      end
    end
    for (int b = 0; b < NB; b += BPR)
      predicted[b] = want_syms[item_lhs[b*SW +: SW]];
  end

endmodule

// File: rtl/pt_table_mem.sv
module pt_table_mem #(
  parameter int NB   = 32,
  parameter int NMAX = 8,
  localparam int CW  = $clog2(NMAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr_en,
  input  logic [CW-1:0] wr_row,
  input  logic [CW-1:0] wr_col,
  input  logic [NB-1:0] wr_data,
  input  logic [CW-1:0] rd_row,
  input  logic [CW-1:0] rd_col,
  output logic [NB-1:0] rd_data
);

  logic [NB-1:0] cells [0:NMAX][0:NMAX];
  logic          rd_in_range;

  assign rd_in_range = (rd_row <= CW'(NMAX)) && (rd_col <= CW'(NMAX));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int r = 0; r <= NMAX; r++)
        for (int c = 0; c <= NMAX; c++)
          cells[r][c] <= '0;
    end else if (wr_en) begin
      cells[wr_row][wr_col] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= rd_in_range ? cells[rd_row][rd_col] : '0;
  end

  // R7: writes only land on or above the diagonal
  a_r7_write_upper: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_row <= wr_col && wr_col <= CW'(NMAX)));

endmodule

// File: rtl/pt_diag_builder.sv
module pt_diag_builder
  import pt_pkg::*;
#(
  parameter int NRULE  = 8,
  parameter int MAXLEN = 3,
  parameter int NSYM   = 8,
  parameter int NMAX   = 8,
  localparam int SW  = $clog2(NSYM),
  localparam int LW  = $clog2(MAXLEN + 1),
  localparam int BPR = MAXLEN + 1,
  localparam int NB  = NRULE * BPR,
  localparam int CW  = $clog2(NMAX + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        start,
  input  logic [CW-1:0]               n_in,
  input  logic [NRULE*SW-1:0]         rule_lhs,
  input  logic [NRULE*LW-1:0]         rule_len,
  input  logic [NRULE*MAXLEN*SW-1:0]  rule_rhs,
  input  logic [CW-1:0]               rd_row,
  input  logic [CW-1:0]               rd_col,
  output logic [NB-1:0]               rd_data,
  output logic                        col_done,
  output logic [CW-1:0]               col_idx,
  output logic                        accept
);

  pt_state_e     st;
  logic [CW-1:0] n_q, j_q, k_q, i_q;
  logic [NB-1:0] acc;
  logic [NB-1:0] rowbuf [0:NMAX];

  // decoded grammar
  logic [NB-1:0]    item_end, item_open;
  logic [NB*SW-1:0] item_next, item_lhs;

  pt_rule_decode #(.NRULE(NRULE), .MAXLEN(MAXLEN), .NSYM(NSYM)) u_dec (
    .rule_lhs (rule_lhs),
    .rule_len (rule_len),
    .rule_rhs (rule_rhs),
    .item_end (item_end),
    .item_open(item_open),
    .item_next(item_next),
    .item_lhs (item_lhs)
  );

  // operand selection for the single combine unit
  logic [NB-1:0] opa, opb;
  logic [NB-1:0] scan_adv, comp_adv, predicted;

  always_comb begin
    opa = '0;
    opb = '0;
    unique case (st)
      ST_CLOSE0: opa = acc;
      ST_SCAN:   opa = rowbuf[j_q - CW'(1)];
      ST_COMP: begin
        opa = rowbuf[k_q];
        opb = rowbuf[j_q - k_q];
      end
      ST_CLOSE: begin
        opa = rowbuf[0];
        opb = acc;
      end
      default: ;
    endcase
  end

  pt_combine #(.NRULE(NRULE), .MAXLEN(MAXLEN), .NSYM(NSYM)) u_comb (
    .left_cell (opa),
    .right_cell(opb),
    .item_end  (item_end),
    .item_open (item_open),
    .item_next (item_next),
    .item_lhs  (item_lhs),
    .scan_adv  (scan_adv),
    .comp_adv  (comp_adv),
    .predicted (predicted)
  );

  // named internal events
  logic          go;
  logic          wr_en;
  logic [CW-1:0] wr_row, wr_col;
  logic          col_end;
  logic          pred_settled, comp_settled;
  logic [NB-1:0] pred_next, comp_next;
  logic [NB-1:0] goal_mask;
  logic          goal_hit;

  assign go           = (st == ST_IDLE) && start &&
                        (n_in != '0) && (n_in <= CW'(NMAX));
  assign wr_en        = (st == ST_REPL);
  assign wr_row       = i_q;
  assign wr_col       = i_q + j_q;
  assign col_end      = wr_en && (wr_col == n_q);
  assign pred_next    = acc | predicted;
  assign comp_next    = acc | comp_adv;
  assign pred_settled = (pred_next == acc);
  assign comp_settled = (comp_next == acc);
  assign goal_mask    = NB'(1) << rule_len[LW-1:0];
  assign goal_hit     = |(acc & goal_mask);

  pt_table_mem #(.NB(NB), .NMAX(NMAX)) u_mem (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (go),
    .wr_en  (wr_en),
    .wr_row (wr_row),
    .wr_col (wr_col),
    .wr_data(acc),
    .rd_row (rd_row),
    .rd_col (rd_col),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      n_q      <= '0;
      j_q      <= '0;
      k_q      <= '0;
      i_q      <= '0;
      acc      <= '0;
      accept   <= 1'b0;
      col_done <= 1'b0;
      col_idx  <= '0;
      for (int x = 0; x <= NMAX; x++) rowbuf[x] <= '0;
    end else begin
      col_done <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          if (go) begin
            n_q    <= n_in;
            accept <= 1'b0;
            st     <= ST_SEED;
          end
        end
        ST_SEED: begin
          acc <= NB'(1);
          st  <= ST_CLOSE0;
        end
        ST_CLOSE0: begin
          if (pred_settled) begin
            rowbuf[0] <= acc;
            j_q       <= '0;
            i_q       <= '0;
            st        <= ST_REPL;
          end else begin
            acc <= pred_next;
          end
        end
        ST_SCAN: begin
          acc <= scan_adv;
          k_q <= CW'(1);
          st  <= ST_COMP;
        end
        ST_COMP: begin
          if (k_q < j_q) begin
            acc <= comp_next;
            k_q <= k_q + CW'(1);
          end else begin
            st <= ST_CLOSE;
          end
        end
        ST_CLOSE: begin
          if (comp_settled) begin
            rowbuf[j_q] <= acc;
            i_q         <= '0;
            st          <= ST_REPL;
          end else begin
            acc <= comp_next;
          end
        end
        ST_REPL: begin
          if (col_end) begin
            col_done <= 1'b1;
            col_idx  <= j_q;
            i_q      <= '0;
            if (j_q == n_q) begin
              accept <= goal_hit;
              st     <= ST_IDLE;
            end else begin
              j_q <= j_q + CW'(1);
              st  <= ST_SCAN;
            end
          end else begin
            i_q <= i_q + CW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R8: strobes never fall on adjacent cycles
  a_r8_strobe_gap: assert property (@(posedge clk) disable iff (!rst_n)
    col_done |=> !col_done);

  // R6: every replication write stays on the current diagonal inside the triangle
  a_r6_repl_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_col <= n_q && (wr_col - wr_row) == j_q));

  // R5: closure passes only ever add items
  a_r5_close_grows: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_CLOSE || st == ST_CLOSE0) |=> ((acc & $past(acc)) == $past(acc)));

  // R9: the flag moves only on an accepted start or at a column end
  a_r9_accept_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!go && !col_end) |=> $stable(accept));

  // R2: the latched length cannot change during a build
  a_r2_len_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_IDLE) |=> $stable(n_q));

endmodule

// File: tb/sim_pt_diag_builder.sv
module sim_pt_diag_builder;

  localparam int NRULE  = 8;
  localparam int MAXLEN = 3;
  localparam int NSYM   = 8;
  localparam int NMAX   = 8;
  localparam int SW  = $clog2(NSYM);
  localparam int LW  = $clog2(MAXLEN + 1);
  localparam int BPR = MAXLEN + 1;
  localparam int NB  = NRULE * BPR;
  localparam int CW  = $clog2(NMAX + 1);

  logic                       clk = 1'b0;
  logic                       rst_n = 1'b0;
  logic                       start = 1'b0;
  logic [CW-1:0]              n_in = '0;
  logic [NRULE*SW-1:0]        rule_lhs;
  logic [NRULE*LW-1:0]        rule_len;
  logic [NRULE*MAXLEN*SW-1:0] rule_rhs;
  logic [CW-1:0]              rd_row = '0;
  logic [CW-1:0]              rd_col = '0;
  logic [NB-1:0]              rd_data;
  logic                       col_done;
  logic [CW-1:0]              col_idx;
  logic                       accept;

  always #5 clk = ~clk;

  pt_diag_builder #(.NRULE(NRULE), .MAXLEN(MAXLEN), .NSYM(NSYM), .NMAX(NMAX)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .n_in(n_in),
    .rule_lhs(rule_lhs), .rule_len(rule_len), .rule_rhs(rule_rhs),
    .rd_row(rd_row), .rd_col(rd_col), .rd_data(rd_data),
    .col_done(col_done), .col_idx(col_idx), .accept(accept)
  );

  // grammar held by the bench
  int g_lhs [NRULE];
  int g_len [NRULE];
  int g_rhs [NRULE][MAXLEN];

  always_comb begin
    for (int r = 0; r < NRULE; r++) begin
      rule_lhs[r*SW +: SW] = SW'(g_lhs[r]);
      rule_len[r*LW +: LW] = LW'(g_len[r]);
      for (int d = 0; d < MAXLEN; d++)
        rule_rhs[(r*MAXLEN + d)*SW +: SW] = SW'(g_rhs[r][d]);
    end
  end

  int nchecks = 0;
  int nerrors = 0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    nchecks++;
    if (!ok) begin
      nerrors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // reference table, built by the full recurrence over every cell
  logic [NB-1:0] mt [0:NMAX][0:NMAX];

  function automatic int nxt_of(input int r, input int d);
    return (d < g_len[r]) ? g_rhs[r][d] : -1;
  endfunction

  function automatic logic [NB-1:0] m_scan(input logic [NB-1:0] a);
    logic [NB-1:0] o = '0;
    for (int r = 0; r < NRULE; r++)
      for (int d = 0; d < MAXLEN; d++)
        if (a[r*BPR+d] && nxt_of(r, d) == 0) o[r*BPR+d+1] = 1'b1;
    return o;
  endfunction

  function automatic logic [NB-1:0] m_comp(input logic [NB-1:0] a, input logic [NB-1:0] b);
    logic [NB-1:0] o = '0;
    for (int r2 = 0; r2 < NRULE; r2++)
      if (b[r2*BPR + g_len[r2]])
        for (int r = 0; r < NRULE; r++)
          for (int d = 0; d < MAXLEN; d++)
            if (a[r*BPR+d] && nxt_of(r, d) == g_lhs[r2] && g_lhs[r2] != 0)
              o[r*BPR+d+1] = 1'b1;
    return o;
  endfunction

  function automatic logic [NB-1:0] m_predict_all(input logic [NB-1:0] a);
    logic [NB-1:0] x = a;
    logic [NB-1:0] prev;
    do begin
      prev = x;
      for (int r = 0; r < NRULE; r++)
        for (int d = 0; d < MAXLEN; d++)
          if (prev[r*BPR+d] && nxt_of(r, d) > 0)
            for (int q = 0; q < NRULE; q++)
              if (g_lhs[q] == nxt_of(r, d)) x[q*BPR] = 1'b1;
    end while (x != prev);
    return x;
  endfunction

  task automatic model_build(input int n);
    logic [NB-1:0] x, prev, d0;
    for (int r = 0; r <= NMAX; r++)
      for (int c = 0; c <= NMAX; c++) mt[r][c] = '0;
    d0 = m_predict_all(NB'(1));
    for (int i = 0; i <= n; i++) mt[i][i] = d0;
    for (int dd = 1; dd <= n; dd++)
      for (int i = 0; i + dd <= n; i++) begin
        x = m_scan(mt[i][i+dd-1]);
        for (int k = i + 1; k < i + dd; k++) x = x | m_comp(mt[i][k], mt[k][i+dd]);
        do begin
          prev = x;
          x = x | m_comp(mt[i][i], x);
        end while (x != prev);
        mt[i][i+dd] = x;
      end
  endtask

  // scoreboard of expected column strobes
  int exp_q [$];
  logic prev_done = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (col_done) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8", "unexpected column strobe", 64'(col_idx), 64'hFF);
        end else begin
          int e;
          e = exp_q.pop_front();
          chk(int'(col_idx) == e, "R8", "column order", 64'(col_idx), 64'(e));
        end
      end
      if (prev_done && col_done)
        chk(1'b0, "R8", "adjacent strobes", 64'd1, 64'd0);
      prev_done <= col_done;
    end
  end

  task automatic clear_grammar();
    for (int r = 0; r < NRULE; r++) begin
      g_lhs[r] = NSYM - 1;
      g_len[r] = 1;
      for (int d = 0; d < MAXLEN; d++) g_rhs[r][d] = 0;
    end
  endtask

  task automatic read_cell(input int r, input int c, output logic [NB-1:0] v);
    @(negedge clk);
    rd_row = CW'(r);
    rd_col = CW'(c);
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic pulse_start(input int n);
    @(negedge clk);
    start = 1'b1;
    n_in  = CW'(n);
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_build(input int n, input bit poke_busy);
    exp_q.delete();
    for (int c = 0; c <= n; c++) exp_q.push_back(c);
    model_build(n);
    pulse_start(n);
    if (poke_busy) begin
      repeat (2) @(negedge clk);
      pulse_start(2);   // R2: must be ignored mid-build
    end
    begin
      int t = 0;
      while (exp_q.size() != 0 && t < 3000) begin
        @(negedge clk);
        t++;
      end
      chk(exp_q.size() == 0, "R8", "all column strobes seen", 64'(exp_q.size()), 64'd0);
    end
    repeat (3) @(negedge clk);
    chk(accept == mt[0][n][g_len[0]], "R9", "accept against cell (0,n)",
        64'(accept), 64'(mt[0][n][g_len[0]]));
  endtask

  task automatic check_table(input int n);
    logic [NB-1:0] v;
    for (int r = 0; r <= NMAX; r++)
      for (int c = 0; c <= NMAX; c++) begin
        string tag;
        read_cell(r, c, v);
        if (r == c && r <= n)       tag = "R4";
        else if (r < c && c <= n)   tag = "R6";
        else                        tag = "R7";
        chk(v == mt[r][c], tag, $sformatf("cell (%0d,%0d)", r, c),
            64'(v), 64'(mt[r][c]));
      end
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    nerrors++;
    nchecks++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  CHECKS %0d ERRORS %0d", nchecks, nerrors);
    $finish;
  end

  initial begin
    logic [NB-1:0] v;
    clear_grammar();
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk(accept == 1'b0, "R1", "accept after reset", 64'(accept), 64'd0);
    chk(col_done == 1'b0, "R1", "strobe after reset", 64'(col_done), 64'd0);
    read_cell(0, 0, v);
    chk(v == '0, "R1", "cell (0,0) after reset", 64'(v), 64'd0);
    read_cell(3, 5, v);
    chk(v == '0, "R1", "cell (3,5) after reset", 64'(v), 64'd0);

    // Grammar A: G(1)->P(2); P->C(3) P; P->C; C->d. Accepts every n >= 1.
    clear_grammar();
    g_lhs[0] = 1; g_len[0] = 1; g_rhs[0][0] = 2;
    g_lhs[1] = 2; g_len[1] = 2; g_rhs[1][0] = 3; g_rhs[1][1] = 2;
    g_lhs[2] = 2; g_len[2] = 1; g_rhs[2][0] = 3;
    g_lhs[3] = 3; g_len[3] = 1; g_rhs[3][0] = 0;
    run_build(4, 1'b1);
    chk(accept == 1'b1, "R5", "grammar A accepts n=4", 64'(accept), 64'd1);
    // R3/R5: items G->P., P->C P with dot 1, P->C., C->d. sit at bits 1,5,9,13
    read_cell(0, 1, v);
    chk(v == NB'(32'h2222), "R5", "cell (0,1) of grammar A", 64'(v), 64'h2222);
    read_cell(2, 3, v);
    chk(v == NB'(32'h2222), "R6", "cell (2,3) copies (0,1)", 64'(v), 64'h2222);
    check_table(4);

    // Grammar B: G->E(2); E->d d; E->E E. Accepts even n.
    clear_grammar();
    g_lhs[0] = 1; g_len[0] = 1; g_rhs[0][0] = 2;
    g_lhs[1] = 2; g_len[1] = 2; g_rhs[1][0] = 0; g_rhs[1][1] = 0;
    g_lhs[2] = 2; g_len[2] = 2; g_rhs[2][0] = 2; g_rhs[2][1] = 2;
    run_build(3, 1'b0);
    chk(accept == 1'b0, "R9", "grammar B rejects n=3", 64'(accept), 64'd0);
    check_table(3);
    run_build(4, 1'b0);
    chk(accept == 1'b1, "R9", "grammar B accepts n=4", 64'(accept), 64'd1);
    check_table(4);

    // R2: starts with an out-of-range length are ignored
    pulse_start(0);
    repeat (30) @(negedge clk);
    pulse_start(NMAX + 1);
    repeat (30) @(negedge clk);
    chk(accept == 1'b1, "R2", "flag kept after ignored starts", 64'(accept), 64'd1);
    read_cell(0, 4, v);
    chk(v == mt[0][4], "R2", "cell (0,4) kept after ignored starts", 64'(v), 64'(mt[0][4]));

    // Grammar C: G->d d d. Only n=3 is accepted.
    clear_grammar();
    g_lhs[0] = 1; g_len[0] = 3;
    run_build(3, 1'b0);
    chk(accept == 1'b1, "R9", "grammar C accepts n=3", 64'(accept), 64'd1);
    read_cell(1, 1, v);
    chk(v == NB'(1), "R4", "diagonal holds start item only", 64'(v), 64'd1);
    read_cell(0, 2, v);
    chk(v == NB'(4), "R3", "cell (0,2) is rule 0 dot 2", 64'(v), 64'd4);
    check_table(3);
    run_build(NMAX, 1'b1);
    chk(accept == 1'b0, "R9", "grammar C rejects n=NMAX", 64'(accept), 64'd0);
    check_table(NMAX);

    // R10: out-of-range addresses read zero
    read_cell(NMAX + 1, 2, v);
    chk(v == '0, "R10", "row above NMAX", 64'(v), 64'd0);
    read_cell(0, NMAX + 2, v);
    chk(v == '0, "R10", "column above NMAX", 64'(v), 64'd0);

    $display("  CHECKS %0d ERRORS %0d", nchecks, nerrors);
    $finish;
  end

endmodule